// File: doc/BRIEF.md
# Reed-Solomon (10,4) Parity Encoder

This block computes the four check bytes of a systematic (10,4) Reed-Solomon code over GF(2^8). Each clock cycle it can accept one stripe of ten data bytes, one byte per data drive. It produces four parity bytes, one for each parity drive. Each parity byte is the field dot product of the stripe with one column of a fixed 10x4 coefficient matrix. The ten data bytes come out unchanged and aligned with their parity, so a storage path can write all fourteen bytes in the same cycle. With the identity part of the code, any ten of the fourteen stored bytes are enough to rebuild the stripe.

The coefficient matrix has been scaled so that its first row and first column are all ones. Parity byte 0 is therefore a plain XOR of the stripe, and data byte 0 goes into every parity byte without a multiply. The encoder needs only 27 constant multipliers. Each one is an XOR network fixed by its constant, so there is no general multiplier. The pipeline is two cycles deep and accepts a new stripe on every cycle.

Top module: `rs10_4_parity_enc`

## Requirements
- R1: Field products use GF(2^8) with the reduction x^8 = x^4 + x^3 + x + 1 (0x11B), and field addition is bitwise XOR. For example, 0x80 times 0x02 gives 0x1B.
- R2: Parity byte 0, on out_par[7:0], is the XOR of all ten data bytes.
- R3: Data byte 0, on in_data[7:0], has coefficient 0x01 in all four parity bytes.
- R4: Parity byte 1, on out_par[15:8], takes the coefficients 2c 45 2d d9 fe 5e 2e 30 3c for data bytes 1 to 9.
- R5: Parity byte 2, on out_par[23:16], takes the coefficients 5e 4e c6 7a d0 53 da f6 a4 for data bytes 1 to 9.
- R6: Parity byte 3, on out_par[31:24], takes the coefficients 2e 1e b1 94 56 da 7e 85 d5 for data bytes 1 to 9.
- R7: A stripe accepted at a rising edge with in_valid high produces out_valid high exactly two rising edges later. Stripes given on back-to-back cycles come out on back-to-back cycles.
- R8: out_data carries the ten data bytes unchanged, in the same byte lanes as in_data, in the same cycle as their parity.
- R9: While rst_n is low and after it is released, out_valid is low until a stripe comes through.
- R10: A cycle with in_valid low produces no out_valid two cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A stripe is present on in_data |
| in_data | input | 80 | Data byte k on bits 8k+7:8k |
| out_valid | output | 1 | out_par and out_data hold a result |
| out_par | output | 32 | Parity byte j on bits 8j+7:8j |
| out_data | output | 80 | Stripe delayed to align with its parity |

## Verification
The assertions assume that in_valid is low and in_data is defined during reset. They also assume the inputs are stable when they are sampled. The pass-through and latency properties compare with values from two edges earlier, so they only mean something once both of those edges have been driven. The bench holds in_valid low and in_data at zero from time zero through reset. It changes inputs only on falling edges. Its stimulus mixes back-to-back stripes with idle cycles, so the valid pipeline is checked in both states.

// File: rtl/rs10_4_parity_enc.sv
module rs10_4_parity_enc (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [79:0] in_data,
  output logic        out_valid,
  output logic [31:0] out_par,
  output logic [79:0] out_data
);
  localparam int W     = 8;
  localparam int NDATA = 10;
  localparam int NPAR  = 4;
  localparam int NMUL  = NDATA - 1;
  localparam logic [W-1:0] POLY_LOW = 8'h1B;

  localparam logic [W-1:0] COEF [NPAR-1][NMUL] = '{
    '{8'h2c, 8'h45, 8'h2d, 8'hd9, 8'hfe, 8'h5e, 8'h2e, 8'h30, 8'h3c},
    '{8'h5e, 8'h4e, 8'hc6, 8'h7a, 8'hd0, 8'h53, 8'hda, 8'hf6, 8'ha4},
    '{8'h2e, 8'h1e, 8'hb1, 8'h94, 8'h56, 8'hda, 8'h7e, 8'h85, 8'hd5}
  };

  function automatic logic [W-1:0] mulc(input logic [W-1:0] a, input logic [W-1:0] c);
    logic [W-1:0] p, acc;
    p = a;
    acc = '0;
    for (int i = 0; i < W; i++) begin
      if (c[i]) acc ^= p;
      p = {p[W-2:0], 1'b0} ^ (p[W-1] ? POLY_LOW : '0);
    end
    return acc;
  endfunction

  logic              v1;
  logic [79:0]       d1;
  logic [W-1:0]      prod [NPAR-1][NMUL];
  logic [31:0]       par_next;

  always_ff @(posedge clk) begin
    if (!rst_n) v1 <= 1'b0;
    else        v1 <= in_valid;
    d1 <= in_data;
  end

  for (genvar j = 0; j < NPAR-1; j++) begin : g_col
    for (genvar r = 0; r < NMUL; r++) begin : g_row
      always_ff @(posedge clk)
        prod[j][r] <= mulc(in_data[(r+1)*W +: W], COEF[j][r]);
    end
  end

  always_comb begin
    par_next = '0;
    for (int r = 0; r < NDATA; r++) par_next[W-1:0] ^= d1[r*W +: W];
    for (int j = 1; j < NPAR; j++) begin
      par_next[j*W +: W] = d1[W-1:0];
      for (int r = 0; r < NMUL; r++) par_next[j*W +: W] ^= prod[j-1][r];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= v1;
    out_par  <= par_next;
    out_data <= d1;
  end

  assert_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ##1 out_valid);
  assert_bubble_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ##1 !out_valid);
  assert_passthru_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ##1 (out_data == $past(in_data, 2)));
  assert_xor_col_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_par[7:0] == (out_data[7:0] ^ out_data[15:8] ^ out_data[23:16] ^
      out_data[31:24] ^ out_data[39:32] ^ out_data[47:40] ^ out_data[55:48] ^
      out_data[63:56] ^ out_data[71:64] ^ out_data[79:72])));
  assert_row0_ones_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_data[79:8] == '0) |-> (out_par == {4{out_data[7:0]}}));
endmodule

// File: tb/rs10_4_parity_enc_test.sv
module rs10_4_parity_enc_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [79:0] in_data = '0;
  logic        out_valid;
  logic [31:0] out_par;
  logic [79:0] out_data;

  int checks = 0;
  int errors = 0;
  bit         hv [2];
  logic [79:0] hd [2];
  string      ht [2];

  rs10_4_parity_enc uut (.*);

  always #2 clk = ~clk;

  logic [7:0] cm [3][9];
  initial begin
    cm[0] = '{8'h2c, 8'h45, 8'h2d, 8'hd9, 8'hfe, 8'h5e, 8'h2e, 8'h30, 8'h3c};
    cm[1] = '{8'h5e, 8'h4e, 8'hc6, 8'h7a, 8'hd0, 8'h53, 8'hda, 8'hf6, 8'ha4};
    cm[2] = '{8'h2e, 8'h1e, 8'hb1, 8'h94, 8'h56, 8'hda, 8'h7e, 8'h85, 8'hd5};
  end

  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [15:0] x;
    x = '0;
    for (int i = 0; i < 8; i++) if (b[i]) x ^= 16'(a) << i;
    for (int i = 15; i >= 8; i--) if (x[i]) x ^= 16'h11B << (i - 8);
    return x[7:0];
  endfunction

  function automatic logic [31:0] ref_par(input logic [79:0] d);
    logic [31:0] p;
    p = '0;
    for (int r = 0; r < 10; r++) p[7:0] ^= d[r*8 +: 8];
    for (int j = 1; j < 4; j++) begin
      p[j*8 +: 8] = d[7:0];
      for (int r = 1; r < 10; r++) p[j*8 +: 8] ^= gmul(d[r*8 +: 8], cm[j-1][r-1]);
    end
    return p;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_out();
    if (hv[1]) begin
      chk(out_valid === 1'b1, "R7 valid", 80'(out_valid), 80'd1);
      chk(out_par === ref_par(hd[1]), ht[1], 80'(out_par), 80'(ref_par(hd[1])));
      chk(out_data === hd[1], "R8 passthru", out_data, hd[1]);
    end else begin
      chk(out_valid === 1'b0, "R10 bubble", 80'(out_valid), 80'd0);
    end
  endtask

  task automatic step(input bit v, input logic [79:0] d, input string t);
    @(negedge clk);
    check_out();
    hv[1] = hv[0]; hd[1] = hd[0]; ht[1] = ht[0];
    hv[0] = v; hd[0] = d; ht[0] = t;
    in_valid = v;
    in_data = d;
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [79:0] d;
    void'($urandom(32'd1234));
    hv = '{0, 0};
    hd = '{80'd0, 80'd0};
    ht = '{"", ""};
    repeat (3) @(negedge clk);
    chk(out_valid === 1'b0, "R9 in reset", 80'(out_valid), 80'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid === 1'b0, "R9 after reset", 80'(out_valid), 80'd0);
    step(1'b1, '0, "R2 all zero");
    step(1'b1, {10{8'hFF}}, "R2 all ones");
    step(1'b1, 80'h5A, "R3 row0 only");
    for (int r = 1; r < 10; r++) begin
      step(1'b1, 80'(8'h01) << (r*8), "R4 R5 R6 unit coef");
      step(1'b1, 80'(8'h80) << (r*8), "R1 reduction top bit");
    end
    for (int b = 0; b < 80; b++) step(1'b1, 80'd1 << b, "R1 single bit");
    step(1'b0, '0, "R10");
    step(1'b1, {8'h03, 72'd0}, "R6 lane9");
    step(1'b0, '0, "R10");
    step(1'b0, '0, "R10");
    for (int n = 0; n < 400; n++) begin
      d = {$urandom, $urandom, $urandom};
      step(($urandom % 4) != 0, d, "R4 R5 R6 random");
    end
    for (int n = 0; n < 3; n++) step(1'b0, '0, "R10 drain");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule